// File: doc/BRIEF.md
# PCM Timeslot Engine

This block moves PCM samples between a frame-synchronous serial line and a parallel core interface for one channel side. A bit clock and a frame sync come in from the line. Both are oversampled in the system clock domain. The rising edge of frame sync restarts a bit counter, and that counter splits the frame into slots. The slots are 8 bits wide when the channel compresses and 4 bits wide when it expands. During the programmed input slot, the serial input is shifted in MSB-first and the word is handed to the core on a valid/ready stream. During the programmed output slot, a word taken from the core on a second valid/ready stream is driven MSB-first with the output enable raised.

Idle mode takes the channel off the line. The output enable stays low and no input is captured. Bypass mode routes the captured input slot straight to the output slot with no arithmetic, which lets a system swap timeslots. A strap-style mode forces both slot numbers to zero, for systems without a host.

Stream rules. The receive stream (`rx_valid_o`/`rx_ready_i`) holds a word until the core accepts it. If a newer capture completes first, it replaces the waiting word; the line cannot be stalled. The transmit stream (`tx_valid_i`/`tx_ready_o`) loads a one-word holding register. The engine empties that register at the first bit of each output slot. If no new word has arrived by then, the previous word is sent again.

Top module: `pcm_slot_engine`

## Requirements
- R1: Each bit time begins at a rising bit-clock edge. The rising edge at which frame sync is first seen high starts bit 0 of slot 0. Until the first frame sync after reset, no slot is active and the output enable stays low.
- R2: With `wide_i`=1, slot n spans bits 8n to 8n+7. With `wide_i`=0, slot n spans bits 4n to 4n+3.
- R3: In the input slot, `sdata_i` is sampled on falling bit-clock edges, MSB first. At the last bit the word appears on `rx_data_o` and `rx_valid_o` rises. In 4-bit mode the nibble sits in bits 3:0 and bits 7:4 are zero.
- R4: `rx_valid_o` stays high with `rx_data_o` stable until `rx_ready_i` is seen high. A capture that completes before acceptance replaces the waiting word.
- R5: `sdata_oe_o` is high for exactly the bit times of the output slot. In those bit times `sdata_o` carries the word MSB first, changing after rising bit-clock edges. In 4-bit mode the word's bits 3:0 are sent.
- R6: `tx_ready_o` is high when the holding register is empty and bypass is inactive. A word is accepted when `tx_valid_i` and `tx_ready_o` are both high. The held word is consumed at bit 0 of the output slot. If no newer word was accepted, the previous word is sent again.
- R7: With `idle_i`=1, `sdata_oe_o` is low and no input is captured.
- R8: Bypass is active when `bypass_i`=1 and `idle_i`=0. The captured input slot is then sent unchanged in the output slot, as a byte or a nibble according to `wide_i`. `rx_valid_o` does not rise and `tx_ready_o` is low. If the output slot comes before the input slot, the word goes out in the next frame.
- R9: With `hw_mode_i`=1, both the input slot and the output slot are slot 0, whatever the slot registers hold.
- R10: An output slot that lies wholly beyond `FRAME_BITS` never raises `sdata_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the line |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Line bit clock |
| fsync_i | input | 1 | Line frame sync |
| sdata_i | input | 1 | Serial PCM input |
| wide_i | input | 1 | 1 = 8-bit slots (compress), 0 = 4-bit slots (expand) |
| idle_i | input | 1 | Channel idle |
| bypass_i | input | 1 | Bypass request |
| hw_mode_i | input | 1 | Forces both slots to 0 |
| in_slot_i | input | SLOT_W | Input slot number |
| out_slot_i | input | SLOT_W | Output slot number |
| sdata_o | output | 1 | Serial PCM output |
| sdata_oe_o | output | 1 | Output enable; low means high impedance |
| rx_valid_o | output | 1 | Captured word available |
| rx_ready_i | input | 1 | Core accepts captured word |
| rx_data_o | output | 8 | Captured word |
| tx_valid_i | input | 1 | Core offers a word to send |
| tx_ready_o | output | 1 | Holding register can accept |
| tx_data_i | input | 8 | Word to send |

## Verification
The hardest case to reach is a bypass word that crosses a frame boundary. The output slot comes before the input slot, so the word captured in one frame must survive the frame-sync restart and go out early in the next frame. The bench runs two consecutive frames for this case. It programs the input slot after the output slot, sends a known nibble only in the first frame, and checks the output slot of the second frame. The replacement rule for an unaccepted receive word is reached the same way: the bench holds ready low across two frames.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int unsigned WORD_BITS   = 8;
  localparam int unsigned NIBBLE_BITS = 4;

  typedef enum logic {
    SRC_CORE   = 1'b0,
    SRC_BYPASS = 1'b1
  } tx_src_e;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic         rise0_o,
  output logic         fall0_o
);
  logic [N-1:0] stage_q [STAGES];
  logic         prev0_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev0_q <= 1'b0;
    else        prev0_q <= stage_q[STAGES-1][0];

  assign q_o     = stage_q[STAGES-1];
  assign rise0_o = q_o[0] & ~prev0_q;
  assign fall0_o = ~q_o[0] & prev0_q;
endmodule

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter #(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fs_i,
  input  logic             wide_i,
  output logic             active_o,
  output logic [CNT_W-1:0] slot_o,
  output logic             first_bit_o,
  output logic             last_bit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fs_prev_q;
  logic [2:0]       bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_W'(FRAME_BITS);
      fs_prev_q <= 1'b0;
    end else if (rise_i) begin
      fs_prev_q <= fs_i;
      if (fs_i && !fs_prev_q)
        cnt_q <= '0;
      else if (cnt_q < CNT_W'(FRAME_BITS))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o    = cnt_q < CNT_W'(FRAME_BITS);
  assign slot_o      = wide_i ? (cnt_q >> 3) : (cnt_q >> 2);
  assign bit_idx     = wide_i ? cnt_q[2:0] : {1'b0, cnt_q[1:0]};
  assign first_bit_o = bit_idx == 3'd0;
  assign last_bit_o  = wide_i ? (bit_idx == 3'd7) : (bit_idx == 3'd3);
endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
  import pcm_slot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_i,
  input  logic                 hit_i,
  input  logic                 last_bit_i,
  input  logic                 wide_i,
  input  logic                 byp_act_i,
  input  logic                 sdi_i,
  input  logic                 rx_ready_i,
  output logic                 rx_valid_o,
  output logic [WORD_BITS-1:0] rx_data_o,
  output logic [WORD_BITS-1:0] byp_word_o
);
  logic [WORD_BITS-1:0] sr_q, sr_next, word;
  logic                 done;

  assign sr_next = {sr_q[WORD_BITS-2:0], sdi_i};
  assign word    = wide_i ? sr_next : {{(WORD_BITS-NIBBLE_BITS){1'b0}}, sr_next[NIBBLE_BITS-1:0]};
  assign done    = sample_i && hit_i && last_bit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= '0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      byp_word_o <= '0;
    end else begin
      if (sample_i && hit_i) sr_q <= sr_next;
      if (done && byp_act_i) begin
        byp_word_o <= word;
        if (rx_ready_i) rx_valid_o <= 1'b0;
      end else if (done) begin
        rx_data_o  <= word;
        rx_valid_o <= 1'b1;
      end else if (rx_ready_i) begin
        rx_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_slot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic                 hit_i,
  input  logic                 first_bit_i,
  input  logic                 wide_i,
  input  logic                 byp_act_i,
  input  logic [WORD_BITS-1:0] byp_word_i,
  input  logic                 tx_valid_i,
  input  logic [WORD_BITS-1:0] tx_data_i,
  output logic                 tx_ready_o,
  output logic                 sdo_o,
  output logic                 oe_o
);
  logic [WORD_BITS-1:0] hold_q, sh_q, src, aligned;
  logic                 full_q, consume;
  tx_src_e              sel;

  assign sel     = byp_act_i ? SRC_BYPASS : SRC_CORE;
  assign src     = (sel == SRC_BYPASS) ? byp_word_i : hold_q;
  assign aligned = wide_i ? src : {src[NIBBLE_BITS-1:0], {(WORD_BITS-NIBBLE_BITS){1'b0}}};
  assign consume = step_i && hit_i && first_bit_i && (sel == SRC_CORE);
  assign tx_ready_o = !full_q && !byp_act_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (tx_valid_i && tx_ready_o) begin
      hold_q <= tx_data_i;
      full_q <= 1'b1;
    end else if (consume) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_o <= 1'b0;
      oe_o  <= 1'b0;
    end else if (step_i) begin
      if (hit_i) begin
        oe_o <= 1'b1;
        if (first_bit_i) begin
          sdo_o <= aligned[WORD_BITS-1];
          sh_q  <= aligned << 1;
        end else begin
          sdo_o <= sh_q[WORD_BITS-1];
          sh_q  <= sh_q << 1;
        end
      end else begin
        oe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_engine.sv
module pcm_slot_engine
  import pcm_slot_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned SLOT_W    = $clog2(FRAME_BITS / NIBBLE_BITS),
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk_i,
  input  logic                 fsync_i,
  input  logic                 sdata_i,
  input  logic                 wide_i,
  input  logic                 idle_i,
  input  logic                 bypass_i,
  input  logic                 hw_mode_i,
  input  logic [SLOT_W-1:0]    in_slot_i,
  input  logic [SLOT_W-1:0]    out_slot_i,
  output logic                 sdata_o,
  output logic                 sdata_oe_o,
  output logic                 rx_valid_o,
  input  logic                 rx_ready_i,
  output logic [WORD_BITS-1:0] rx_data_o,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  input  logic [WORD_BITS-1:0] tx_data_i
);
  logic [2:0]           line_q;
  logic                 rise, fall, rise_d_q;
  logic                 active, first_bit, last_bit;
  logic [CNT_W-1:0]     slot;
  logic [SLOT_W-1:0]    in_eff, out_eff;
  logic                 byp_act, in_hit, out_hit, oe_q;
  logic [WORD_BITS-1:0] byp_word;

  pcm_edge_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sdata_i, fsync_i, bclk_i}),
    .q_o(line_q), .rise0_o(rise), .fall0_o(fall)
  );

  pcm_frame_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fs_i(line_q[1]),
    .wide_i(wide_i), .active_o(active), .slot_o(slot),
    .first_bit_o(first_bit), .last_bit_o(last_bit)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rise_d_q <= 1'b0;
    else        rise_d_q <= rise;

  assign in_eff  = hw_mode_i ? '0 : in_slot_i;
  assign out_eff = hw_mode_i ? '0 : out_slot_i;
  assign byp_act = bypass_i && !idle_i;
  assign in_hit  = active && !idle_i && (slot == CNT_W'(in_eff));
  assign out_hit = active && !idle_i && (slot == CNT_W'(out_eff));

  pcm_rx_capture u_rx (
    .clk(clk), .rst_n(rst_n), .sample_i(fall), .hit_i(in_hit),
    .last_bit_i(last_bit), .wide_i(wide_i), .byp_act_i(byp_act),
    .sdi_i(line_q[2]), .rx_ready_i(rx_ready_i), .rx_valid_o(rx_valid_o),
    .rx_data_o(rx_data_o), .byp_word_o(byp_word)
  );

  pcm_tx_serializer u_tx (
    .clk(clk), .rst_n(rst_n), .step_i(rise_d_q), .hit_i(out_hit),
    .first_bit_i(first_bit), .wide_i(wide_i), .byp_act_i(byp_act),
    .byp_word_i(byp_word), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_ready_o(tx_ready_o), .sdo_o(sdata_o), .oe_o(oe_q)
  );

  assign sdata_oe_o = oe_q && !idle_i;
endmodule

// File: rtl/pcm_slot_engine_chk.sv
module pcm_slot_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic idle_i,
  input logic bypass_i,
  input logic sdata_oe_o,
  input logic rx_valid_o,
  input logic rx_ready_i,
  input logic tx_ready_o
);
  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> rx_valid_o);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe_o |-> !idle_i);

  assert_bypass_no_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> !(bypass_i && !idle_i));

  assert_bypass_no_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> !$past(bypass_i && !idle_i));
endmodule

bind pcm_slot_engine pcm_slot_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .bypass_i(bypass_i),
  .sdata_oe_o(sdata_oe_o), .rx_valid_o(rx_valid_o),
  .rx_ready_i(rx_ready_i), .tx_ready_o(tx_ready_o)
);

// File: tb/tb_pcm_slot_engine.sv
module tb_pcm_slot_engine;
  localparam int FB = 64;
  localparam int SW = $clog2(FB / 4);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 0, fsync = 0, sdi = 0, wide = 1, idle = 0, bypass = 0, hw = 0;
  logic [SW-1:0] in_slot = '0, out_slot = '0;
  logic sdo, oe, rx_valid, rx_ready = 0, tx_valid = 0, tx_ready;
  logic [7:0] rx_data, tx_data = '0;
  logic [FB-1:0] oe_bits, dout_bits;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcm_slot_engine #(.FRAME_BITS(FB)) dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdi),
    .wide_i(wide), .idle_i(idle), .bypass_i(bypass), .hw_mode_i(hw),
    .in_slot_i(in_slot), .out_slot_i(out_slot), .sdata_o(sdo), .sdata_oe_o(oe),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic one_bit(input logic fs, input logic d, input int idx);
    @(negedge clk); bclk = 1; fsync = fs; sdi = d;
    repeat (7) @(negedge clk);
    if (idx >= 0) begin oe_bits[idx] = oe; dout_bits[idx] = sdo; end
    @(negedge clk); bclk = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_frame(input logic [FB-1:0] din);
    oe_bits = '0; dout_bits = '0;
    for (int i = 0; i < FB; i++) one_bit(i == 0, din[i], i);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [FB-1:0] place(input bit w, input int s, input logic [7:0] v);
    logic [FB-1:0] r = '0;
    int n = w ? 8 : 4;
    for (int k = 0; k < n; k++) if (n*s + k < FB) r[n*s + k] = v[n-1-k];
    return r;
  endfunction

  function automatic logic [FB-1:0] mask(input bit w, input int s);
    return place(w, s, 8'hFF);
  endfunction

  task automatic push_tx(input logic [7:0] v);
    @(negedge clk); tx_data = v; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic clear_rx();
    @(negedge clk); rx_ready = 1; @(negedge clk); rx_ready = 0; @(negedge clk);
  endtask

  task automatic check_out(input string req, input bit w, input int s, input logic [7:0] v);
    check(oe_bits == mask(w, s), {req, " oe window"}, 64'(oe_bits), 64'(mask(w, s)));
    check((dout_bits & mask(w, s)) == place(w, s, v), {req, " data"},
          64'(dout_bits & mask(w, s)), 64'(place(w, s, v)));
  endtask

  task automatic t_reset();
    check(oe == 0 && rx_valid == 0, "R1 reset outputs", {oe, rx_valid}, 0);
    check(tx_ready == 1, "R6 reset ready", tx_ready, 1);
    oe_bits = '0;
    for (int i = 0; i < 12; i++) one_bit(0, 1, i);
    check(oe_bits == 0, "R1 no slot before frame sync", 64'(oe_bits), 0);
  endtask

  task automatic t_byte();
    wide = 1; in_slot = 2; out_slot = 5;
    push_tx(8'hA5);
    check(tx_ready == 0, "R6 holding full", tx_ready, 0);
    run_frame(place(1, 2, 8'h3C));
    check(rx_valid == 1 && rx_data == 8'h3C, "R3 byte capture", {rx_valid, rx_data}, {1'b1, 8'h3C});
    check_out("R5 R2 byte out", 1, 5, 8'hA5);
    check(tx_ready == 1, "R6 consumed", tx_ready, 1);
    repeat (20) @(negedge clk);
    check(rx_valid == 1 && rx_data == 8'h3C, "R4 held without ready", {rx_valid, rx_data}, {1'b1, 8'h3C});
    clear_rx();
    check(rx_valid == 0, "R4 cleared by ready", rx_valid, 0);
  endtask

  task automatic t_nibble();
    wide = 0; in_slot = 3; out_slot = 9;
    push_tx(8'h0B);
    run_frame(place(0, 3, 8'h06));
    check(rx_valid == 1 && rx_data == 8'h06, "R2 R3 nibble capture", rx_data, 8'h06);
    check_out("R5 nibble out", 0, 9, 8'h0B);
    clear_rx();
  endtask

  task automatic t_repeat_overwrite();
    run_frame(place(0, 3, 8'h09));
    run_frame(place(0, 3, 8'h04));
    check(rx_valid == 1 && rx_data == 8'h04, "R4 newer word replaces", rx_data, 8'h04);
    check_out("R6 repeat last word", 0, 9, 8'h0B);
    clear_rx();
  endtask

  task automatic t_bypass_byte();
    wide = 1; bypass = 1; in_slot = 1; out_slot = 6;
    repeat (3) @(negedge clk);
    check(tx_ready == 0, "R8 tx stream closed", tx_ready, 0);
    run_frame(place(1, 1, 8'hE7));
    check_out("R8 byte bypass", 1, 6, 8'hE7);
    check(rx_valid == 0, "R8 no rx in bypass", rx_valid, 0);
  endtask

  task automatic t_bypass_wrap();
    wide = 0; in_slot = 7; out_slot = 2;
    run_frame(place(0, 7, 8'h0D));
    run_frame('0);
    check_out("R8 nibble bypass next frame", 0, 2, 8'h0D);
    check(rx_valid == 0, "R8 no rx in bypass", rx_valid, 0);
    bypass = 0;
  endtask

  task automatic t_idle();
    idle = 1; wide = 1; in_slot = 0; out_slot = 0;
    run_frame(place(1, 0, 8'hFF));
    check(oe_bits == 0, "R7 idle no drive", 64'(oe_bits), 0);
    check(rx_valid == 0, "R7 idle no capture", rx_valid, 0);
    idle = 0;
  endtask

  task automatic t_hw();
    hw = 1; in_slot = 5; out_slot = 5;
    push_tx(8'h81);
    run_frame(place(1, 0, 8'h42));
    check(rx_data == 8'h42 && rx_valid, "R9 capture slot 0", rx_data, 8'h42);
    check_out("R9 drive slot 0", 1, 0, 8'h81);
    clear_rx();
    hw = 0;
  endtask

  task automatic t_beyond();
    wide = 1; out_slot = 10; in_slot = 0;
    run_frame('0);
    check(oe_bits == 0, "R10 slot past frame", 64'(oe_bits), 0);
    clear_rx();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_byte();
    t_nibble();
    t_repeat_overwrite();
    t_bypass_byte();
    t_bypass_wrap();
    t_idle();
    t_hw();
    t_beyond();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule